// File: doc/BRIEF.md
# Four-State Snooping Coherence Controller

This block keeps coherence state for every line of one direct-mapped write-back cache on a shared snooping bus. Each line is Invalid, Shared, Exclusive (clean, the only copy) or Modified (dirty, the only copy). The processor side issues reads and writes one at a time and holds each request until `cpu_done`. The bus side snoops the transactions of the other caches.

When a processor access cannot be finished locally, the block raises `bus_req` with a command and a line address and waits for `bus_gnt`. It retires a dirty victim before it fetches the new line. It answers each snooped transaction in the same cycle. It drives a shared indication that feeds the wired-OR line, and it tells the data array to supply its copy of a dirty line.

Addresses are line addresses: the low `IDX_W` bits select the line and the remaining bits form the tag. Bus command codes are 0 none, 1 read line, 2 write line, 3 read-and-invalidate, 4 invalidate.

Top module: `mesi_ctrl`

## Requirements
- R1: After reset every line is Invalid. A snooped read gets no shared response, and the first processor read of any address issues a read-line command (code 1).
- R2: A processor read miss issues read-line (code 1) with the requested address. On its grant the line fills into Exclusive if `bus_shared` is low, or into Shared if it is high.
- R3: A processor write to an Exclusive line completes with no bus request and leaves the line Modified.
- R4: A processor write to a Shared line issues invalidate (code 4) and then holds the line Modified.
- R5: A processor write miss issues read-and-invalidate (code 3) and fills into Modified. `dat_fill` is high exactly in the grant cycle of a code 1 or code 3 command.
- R6: A snooped read-line (code 1) that hits a Modified line asserts `snp_supply` and `snp_shared` and moves the line to Shared. On an Exclusive line it asserts only `snp_shared` and moves the line to Shared.
- R7: A snooped read-and-invalidate (3) or invalidate (4) that hits a valid line moves it to Invalid. It asserts `snp_supply` only if the line was Modified, and it never asserts `snp_shared`.
- R8: `snp_shared` is high only during a snooped read-line whose address matches a valid line. A tag mismatch or an Invalid line gives no response.
- R9: A miss whose indexed line is Modified first issues write-line (code 2) carrying the victim's address, with `dat_wb` high in its grant cycle, and then issues the fill command. A clean victim is dropped without write-line.
- R10: A snooped transaction takes precedence over the processor: a request presented in a snoop cycle is evaluated only afterwards. A pending invalidate whose Shared line is invalidated meanwhile becomes read-and-invalidate.
- R11: A processor hit that needs no bus finishes with `cpu_done` one clock after the request is sampled. `cpu_done` is a single-cycle pulse.
- R12: A snooped write-line (code 2) changes no line state and gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until cpu_done |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address of the access |
| cpu_done | output | 1 | Access complete (one-cycle pulse) |
| bus_req | output | 1 | Request for the bus |
| bus_cmd | output | 3 | Command to place on the bus |
| bus_addr | output | ADDR_W | Line address of the command |
| bus_gnt | input | 1 | Bus granted; the command completes this cycle |
| bus_shared | input | 1 | Wired-OR shared line from other caches, sampled at grant |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 3 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds a valid copy of the snooped read line |
| snp_supply | output | 1 | Data array must supply the dirty snooped line |
| dat_index | output | IDX_W | Data-array line index of the processor access |
| dat_fill | output | 1 | Write the bus data into the data array |
| dat_wb | output | 1 | Read the victim out of the data array onto the bus |
| dat_write | output | 1 | Write the processor data into the data array |

## Verification
The bench goes after the transitions a careless design merges. A write to an Exclusive line that still went to the bus would show up as a spurious invalidate. A fill that ignored `bus_shared` would make a later write silent when it must invalidate. A snoop that downgraded a Modified line without `snp_supply` would lose the only current copy. It replaces a dirty victim and checks that write-line carries the victim's address ahead of the fill, and that a clean victim produces no write-back. It also collides a snoop with a processor write in the same cycle, and invalidates a line while its upgrade waits for the bus. A design that let the processor win, or that held on to a stale command, would then issue a silent write or an invalidate for a line it no longer holds.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2,
        LN_MOD = 2'd3
    } line_st_e;

    typedef enum logic [2:0] {
        BC_NONE   = 3'd0,
        BC_RDLINE = 3'd1,
        BC_WRLINE = 3'd2,
        BC_RDINV  = 3'd3,
        BC_INVAL  = 3'd4
    } bus_cmd_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_BUS  = 2'd1,
        FS_DONE = 2'd2
    } fsm_e;

    typedef struct packed {
        fsm_e fsm;
        logic wr;
    } ctl_s;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 5,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output line_st_e         rd_a_state,
    output logic [TAG_W-1:0] rd_a_tag,
    input  logic [IDX_W-1:0] rd_b_idx,
    output line_st_e         rd_b_state,
    output logic [TAG_W-1:0] rd_b_tag,
    input  logic             wa_en,
    input  logic [IDX_W-1:0] wa_idx,
    input  logic [TAG_W-1:0] wa_tag,
    input  line_st_e         wa_state,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  line_st_e         wb_state
);

    line_st_e         st_all [NUM_LINES];
    logic [TAG_W-1:0] tg_all [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_st_e         st_d, st_q;
        logic [TAG_W-1:0] tg_d, tg_q;

        always_comb begin
            st_d = st_q;
            tg_d = tg_q;
            if (wa_en && (wa_idx == IDX_W'(g))) begin
                st_d = wa_state;
                tg_d = wa_tag;
            end
            if (wb_en && (wb_idx == IDX_W'(g))) begin
                st_d = wb_state;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= LN_INV;
                tg_q <= '0;
            end else begin
                st_q <= st_d;
                tg_q <= tg_d;
            end
        end

        assign st_all[g] = st_q;
        assign tg_all[g] = tg_q;
    end

    assign rd_a_state = st_all[rd_a_idx];
    assign rd_a_tag   = tg_all[rd_a_idx];
    assign rd_b_state = st_all[rd_b_idx];
    assign rd_b_tag   = tg_all[rd_b_idx];

endmodule

// File: rtl/mesi_cpu_unit.sv
module mesi_cpu_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic             wr,
    input  logic [TAG_W-1:0] req_tag,
    input  line_st_e         ln_state,
    input  logic [TAG_W-1:0] ln_tag,
    output logic             hit,
    output logic             silent,
    output logic             victim_wb,
    output bus_cmd_e         cmd
);

    always_comb begin
        hit       = (ln_state != LN_INV) && (ln_tag == req_tag);
        silent    = 1'b0;
        victim_wb = 1'b0;
        cmd       = BC_NONE;
        if (hit) begin
            if (!wr) begin
                silent = 1'b1;
            end else if (ln_state == LN_SHR) begin
                cmd = BC_INVAL;
            end else begin
                silent = 1'b1;
            end
        end else if (ln_state == LN_MOD) begin
            victim_wb = 1'b1;
            cmd       = BC_WRLINE;
        end else begin
            cmd = wr ? BC_RDINV : BC_RDLINE;
        end
    end

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic             valid,
    input  bus_cmd_e         cmd,
    input  logic [TAG_W-1:0] tag,
    input  line_st_e         ln_state,
    input  logic [TAG_W-1:0] ln_tag,
    output logic             shared,
    output logic             supply,
    output logic             upd,
    output line_st_e         nxt
);

    logic hit;

    always_comb begin
        hit    = valid && (ln_state != LN_INV) && (ln_tag == tag);
        shared = 1'b0;
        supply = 1'b0;
        upd    = 1'b0;
        nxt    = ln_state;
        if (hit) begin
            case (cmd)
                BC_RDLINE: begin
                    shared = 1'b1;
                    supply = (ln_state == LN_MOD);
                    upd    = 1'b1;
                    nxt    = LN_SHR;
                end
                BC_RDINV, BC_INVAL: begin
                    supply = (ln_state == LN_MOD);
                    upd    = 1'b1;
                    nxt    = LN_INV;
                end
                default: begin
                    upd = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 8,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int TAG_W    = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_done,
    output logic              bus_req,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared,
    input  logic              snp_valid,
    input  logic [2:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic [IDX_W-1:0]  dat_index,
    output logic              dat_fill,
    output logic              dat_wb,
    output logic              dat_write
);

    ctl_s ctl_d, ctl_q;

    logic [IDX_W-1:0] cpu_idx, snp_idx;
    logic [TAG_W-1:0] cpu_tag, snp_tag;
    line_st_e         cl_state, sl_state;
    logic [TAG_W-1:0] cl_tag, sl_tag;

    logic             c_hit, c_silent, c_victim;
    bus_cmd_e         c_cmd;

    logic             s_upd;
    line_st_e         s_nxt;

    logic             wa_en;
    logic [TAG_W-1:0] wa_tag;
    line_st_e         wa_state;
    bus_cmd_e         cmd_out;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    mesi_line_store #(
        .NUM_LINES(NUM_LINES),
        .TAG_W    (TAG_W),
        .IDX_W    (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (cpu_idx),
        .rd_a_state(cl_state),
        .rd_a_tag  (cl_tag),
        .rd_b_idx  (snp_idx),
        .rd_b_state(sl_state),
        .rd_b_tag  (sl_tag),
        .wa_en     (wa_en),
        .wa_idx    (cpu_idx),
        .wa_tag    (wa_tag),
        .wa_state  (wa_state),
        .wb_en     (s_upd),
        .wb_idx    (snp_idx),
        .wb_state  (s_nxt)
    );

    mesi_cpu_unit #(.TAG_W(TAG_W)) u_cpu (
        .wr       (cpu_wr),
        .req_tag  (cpu_tag),
        .ln_state (cl_state),
        .ln_tag   (cl_tag),
        .hit      (c_hit),
        .silent   (c_silent),
        .victim_wb(c_victim),
        .cmd      (c_cmd)
    );

    mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
        .valid   (snp_valid),
        .cmd     (bus_cmd_e'(snp_cmd)),
        .tag     (snp_tag),
        .ln_state(sl_state),
        .ln_tag  (sl_tag),
        .shared  (snp_shared),
        .supply  (snp_supply),
        .upd     (s_upd),
        .nxt     (s_nxt)
    );

    always_comb begin
        ctl_d    = ctl_q;
        wa_en    = 1'b0;
        wa_tag   = cl_tag;
        wa_state = cl_state;
        bus_req  = 1'b0;
        cmd_out  = BC_NONE;
        bus_addr = cpu_addr;
        dat_fill = 1'b0;
        dat_wb   = 1'b0;
        case (ctl_q.fsm)
            FS_IDLE: begin
                if (cpu_req && !snp_valid) begin
                    ctl_d.wr = cpu_wr;
                    if (c_silent) begin
                        if (cpu_wr && (cl_state != LN_MOD)) begin
                            wa_en    = 1'b1;
                            wa_state = LN_MOD;
                        end
                        ctl_d.fsm = FS_DONE;
                    end else begin
                        ctl_d.fsm = FS_BUS;
                    end
                end
            end
            FS_BUS: begin
                if (c_silent) begin
                    if (cpu_wr && (cl_state != LN_MOD) && !snp_valid) begin
                        wa_en    = 1'b1;
                        wa_state = LN_MOD;
                    end
                    ctl_d.fsm = snp_valid ? FS_BUS : FS_DONE;
                end else begin
                    bus_req = 1'b1;
                    cmd_out = c_cmd;
                    if (c_victim) begin
                        bus_addr = {cl_tag, cpu_idx};
                    end
                    if (bus_gnt) begin
                        case (c_cmd)
                            BC_WRLINE: begin
                                wa_en    = 1'b1;
                                wa_state = LN_INV;
                                dat_wb   = 1'b1;
                            end
                            BC_RDLINE: begin
                                wa_en     = 1'b1;
                                wa_tag    = cpu_tag;
                                wa_state  = bus_shared ? LN_SHR : LN_EXC;
                                dat_fill  = 1'b1;
                                ctl_d.fsm = FS_DONE;
                            end
                            BC_RDINV: begin
                                wa_en     = 1'b1;
                                wa_tag    = cpu_tag;
                                wa_state  = LN_MOD;
                                dat_fill  = 1'b1;
                                ctl_d.fsm = FS_DONE;
                            end
                            BC_INVAL: begin
                                wa_en     = 1'b1;
                                wa_state  = LN_MOD;
                                ctl_d.fsm = FS_DONE;
                            end
                            default: begin
                                ctl_d.fsm = FS_BUS;
                            end
                        endcase
                    end
                end
            end
            FS_DONE: begin
                ctl_d.fsm = FS_IDLE;
            end
            default: begin
                ctl_d.fsm = FS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{fsm: FS_IDLE, wr: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_cmd   = cmd_out;
    assign cpu_done  = (ctl_q.fsm == FS_DONE);
    assign dat_write = (ctl_q.fsm == FS_DONE) && ctl_q.wr;
    assign dat_index = cpu_idx;

endmodule

// File: rtl/mesi_ctrl_chk.sv
module mesi_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_done,
    input logic       bus_req,
    input logic [2:0] bus_cmd,
    input logic       bus_gnt,
    input logic       snp_valid,
    input logic [2:0] snp_cmd,
    input logic       snp_shared,
    input logic       snp_supply,
    input logic       dat_wb,
    input logic       dat_fill
);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R3
    done_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !bus_req);

    // R8
    shared_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared |-> (snp_valid && snp_cmd == 3'd1));

    // R7
    supply_on_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_valid && (snp_cmd == 3'd1 || snp_cmd == 3'd3 || snp_cmd == 3'd4)));

    // R9
    wb_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wb |-> (bus_gnt && bus_req && bus_cmd == 3'd2));

    // R5
    fill_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_fill |-> (bus_gnt && bus_req && (bus_cmd == 3'd1 || bus_cmd == 3'd3)));

    // R2
    req_has_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_cmd != 3'd0));

    // R10
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

endmodule

bind mesi_ctrl mesi_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_done  (cpu_done),
    .bus_req   (bus_req),
    .bus_cmd   (bus_cmd),
    .bus_gnt   (bus_gnt),
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_shared(snp_shared),
    .snp_supply(snp_supply),
    .dat_wb    (dat_wb),
    .dat_fill  (dat_fill)
);

// File: tb/mesi_ctrl_bench.sv
module mesi_ctrl_bench;

    localparam int AW = 8;
    localparam logic [2:0] C_NO = 3'd0, C_RD = 3'd1, C_WR = 3'd2, C_RX = 3'd3, C_IV = 3'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_wr = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_done;
    logic          bus_req;
    logic [2:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic          bus_gnt = 1'b0, bus_shared = 1'b0;
    logic          snp_valid = 1'b0;
    logic [2:0]    snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_shared, snp_supply;
    logic [2:0]    dat_index;
    logic          dat_fill, dat_wb, dat_write;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    mesi_ctrl #(.NUM_LINES(8), .ADDR_W(AW)) u_mesi_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_done(cpu_done),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .bus_shared(bus_shared),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_supply(snp_supply),
        .dat_index(dat_index), .dat_fill(dat_fill), .dat_wb(dat_wb), .dat_write(dat_write)
    );

    typedef struct packed {
        logic          snp;
        logic [2:0]    op;
        logic [AW-1:0] addr;
        logic          sh;
        logic [2:0]    c0;
        logic [2:0]    c1;
        logic [AW-1:0] a0;
        logic          esh;
        logic          esup;
        logic [3:0]    rq;
    } vec_t;

    // fields: snoop?, op (cpu: 0 rd / 1 wr; snoop: cmd), addr, shared given,
    // first cmd, second cmd, first addr, expected shared, expected supply, req
    localparam vec_t VECS [17] = '{
        '{1'b0, 3'd0, 8'h01, 1'b0, 3'd1, 3'd0, 8'h01, 1'b0, 1'b0, 4'd2},  // R2 miss, fill E
        '{1'b0, 3'd1, 8'h01, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 1'b0, 4'd3},  // R3 silent E->M
        '{1'b1, 3'd1, 8'h01, 1'b0, 3'd0, 3'd0, 8'h00, 1'b1, 1'b1, 4'd6},  // R6 M -> S, supply
        '{1'b0, 3'd1, 8'h01, 1'b0, 3'd4, 3'd0, 8'h01, 1'b0, 1'b0, 4'd4},  // R4 S write upgrade
        '{1'b1, 3'd3, 8'h01, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 1'b1, 4'd7},  // R7 M -> I, supply
        '{1'b0, 3'd0, 8'h02, 1'b1, 3'd1, 3'd0, 8'h02, 1'b0, 1'b0, 4'd2},  // R2 fill S
        '{1'b0, 3'd0, 8'h02, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 1'b0, 4'd11}, // R11 read hit
        '{1'b1, 3'd4, 8'h02, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 1'b0, 4'd7},  // R7 S -> I
        '{1'b1, 3'd1, 8'h02, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 1'b0, 4'd8},  // R8 invalid, no reply
        '{1'b0, 3'd1, 8'h03, 1'b0, 3'd3, 3'd0, 8'h03, 1'b0, 1'b0, 4'd5},  // R5 write miss
        '{1'b0, 3'd0, 8'h0B, 1'b0, 3'd2, 3'd1, 8'h03, 1'b0, 1'b0, 4'd9},  // R9 dirty victim
        '{1'b1, 3'd1, 8'h03, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 1'b0, 4'd8},  // R8 old tag gone
        '{1'b1, 3'd1, 8'h0B, 1'b0, 3'd0, 3'd0, 8'h00, 1'b1, 1'b0, 4'd6},  // R6 E -> S
        '{1'b0, 3'd0, 8'h13, 1'b0, 3'd1, 3'd0, 8'h13, 1'b0, 1'b0, 4'd9},  // R9 clean victim
        '{1'b1, 3'd2, 8'h13, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 1'b0, 4'd12}, // R12 snooped write line
        '{1'b0, 3'd1, 8'h13, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 1'b0, 4'd12}, // R12 still E: silent
        '{1'b1, 3'd1, 8'h13, 1'b0, 3'd0, 3'd0, 8'h00, 1'b1, 1'b1, 4'd3}   // R3 now M
    };

    task automatic chk(input bit ok, input int rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic snoop(input logic [2:0] cmd, input logic [AW-1:0] a,
                         output logic sh, output logic sup);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
        #1;
        sh = snp_shared; sup = snp_supply;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic cpu_access(input logic wr, input logic [AW-1:0] a, input logic sh,
                              input logic with_snp, input logic [2:0] scmd, input logic [AW-1:0] saddr,
                              output logic [2:0] c0, output logic [2:0] c1, output logic [AW-1:0] a0,
                              output logic wb, output logic fill, output logic dwr,
                              output int lat, output logic done, output logic ssh);
        int n = 0;
        c0 = C_NO; c1 = C_NO; a0 = '0; wb = 0; fill = 0; dwr = 0; lat = -1; done = 0; ssh = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a;
        if (with_snp) begin
            snp_valid = 1'b1; snp_cmd = scmd; snp_addr = saddr;
            #1 ssh = snp_shared;
        end
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            bus_gnt = 1'b0;
            snp_valid = 1'b0;
            #1;
            if (cpu_done) begin
                done = 1; dwr = dat_write; lat = c; cpu_req = 1'b0;
                break;
            end
            if (bus_req) begin
                if (n == 0) begin c0 = bus_cmd; a0 = bus_addr; end
                else if (n == 1) c1 = bus_cmd;
                n++;
                bus_gnt = 1'b1; bus_shared = sh;
                #1;
                wb   = wb | dat_wb;
                fill = fill | dat_fill;
            end
        end
        bus_gnt = 1'b0;
        cpu_req = 1'b0;
    endtask

    vec_t v;
    logic [2:0] r0, r1;
    logic [AW-1:0] ra;
    logic rwb, rfill, rdwr, rdone, rssh, ssh, ssup;
    int rlat;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(bus_req == 1'b0, 1, bus_req, 0);
        chk(cpu_done == 1'b0, 1, cpu_done, 0);
        snoop(C_RD, 8'h00, ssh, ssup);
        chk(ssh == 1'b0, 1, ssh, 0);
        snoop(C_RD, 8'h07, ssh, ssup);
        chk(ssh == 1'b0 && ssup == 1'b0, 1, {ssh, ssup}, 0);
        cpu_access(1'b0, 8'h04, 1'b0, 1'b0, C_NO, 8'h00, r0, r1, ra, rwb, rfill, rdwr, rlat, rdone, rssh);
        chk(r0 == C_RD, 1, r0, C_RD);

        for (int i = 0; i < 17; i++) begin
            v = VECS[i];
            if (v.snp) begin
                snoop(v.op, v.addr, ssh, ssup);
                chk(ssh == v.esh, int'(v.rq), ssh, v.esh);
                chk(ssup == v.esup, int'(v.rq), ssup, v.esup);
            end else begin
                cpu_access(v.op[0], v.addr, v.sh, 1'b0, C_NO, 8'h00,
                           r0, r1, ra, rwb, rfill, rdwr, rlat, rdone, rssh);
                chk(rdone == 1'b1, int'(v.rq), rdone, 1);
                chk(r0 == v.c0, int'(v.rq), r0, v.c0);
                chk(r1 == v.c1, int'(v.rq), r1, v.c1);
                if (v.c0 != C_NO) chk(ra == v.a0, int'(v.rq), ra, v.a0);
                chk(rwb == (v.c0 == C_WR), int'(v.rq), rwb, (v.c0 == C_WR));
                chk(rfill == (v.c0 == C_RD || v.c0 == C_RX || v.c1 == C_RD || v.c1 == C_RX),
                    int'(v.rq), rfill, 1'b0);
                chk(rdwr == v.op[0], int'(v.rq), rdwr, v.op[0]);
                if (v.c0 == C_NO) chk(rlat == 0, int'(v.rq), rlat, 0);
            end
        end

        // R10: snoop in the same cycle as a write to an Exclusive line
        cpu_access(1'b0, 8'h05, 1'b0, 1'b0, C_NO, 8'h00, r0, r1, ra, rwb, rfill, rdwr, rlat, rdone, rssh);
        cpu_access(1'b1, 8'h05, 1'b0, 1'b1, C_RD, 8'h05, r0, r1, ra, rwb, rfill, rdwr, rlat, rdone, rssh);
        chk(rssh == 1'b1, 10, rssh, 1);
        chk(r0 == C_IV, 10, r0, C_IV);

        // R10: pending upgrade loses its Shared copy while waiting
        cpu_access(1'b0, 8'h06, 1'b1, 1'b0, C_NO, 8'h00, r0, r1, ra, rwb, rfill, rdwr, rlat, rdone, rssh);
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = 8'h06;
        @(negedge clk);
        chk(bus_req && bus_cmd == C_IV, 10, bus_cmd, C_IV);
        snp_valid = 1'b1; snp_cmd = C_RX; snp_addr = 8'h06;
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk(bus_req && bus_cmd == C_RX, 10, bus_cmd, C_RX);
        bus_gnt = 1'b1; bus_shared = 1'b0;
        @(negedge clk);
        bus_gnt = 1'b0;
        #1;
        chk(cpu_done == 1'b1, 10, cpu_done, 1);
        cpu_req = 1'b0;
        snoop(C_RD, 8'h06, ssh, ssup);
        chk(ssup == 1'b1, 5, ssup, 1);  // R5 filled into Modified

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule